// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Codec

This block protects a 16-bit word with a 22-bit codeword. Its encode path adds five Hamming check bits and one overall parity bit to the data word. Its decode path takes a stored or received codeword and rebuilds a syndrome from the check bits. It repairs any single flipped bit, wherever that bit sits in the codeword, and reports a flip of two bits as beyond repair. The two paths are independent. Each one is a combinational network followed by a single register stage, so a result appears one clock after its valid input.

The overall parity bit decides whether a repair is attempted. When overall parity fails, the block treats the error as a single flip and uses the syndrome to find the bit. A zero syndrome then means that the parity bit itself was the one hit. When overall parity holds but the syndrome is nonzero, two bits have flipped. In that case the received data field is passed on unchanged and flagged as uncorrectable. Typical uses are a memory-word wrapper, where data is encoded on write and checked on read, and a link-word checker.

Top module: `secded_codec`

## Requirements
- R1: The codeword is laid out by bit index as follows. Bit 0 is the overall parity bit, chosen so that the 22-bit codeword has an even number of ones. Bits 1, 2, 4, 8 and 16 hold check bits. The 16 data bits fill the remaining indices 3, 5, 6, 7, 9 to 15 and 17 to 21, in ascending order, with data bit 0 at index 3 and data bit 15 at index 21.
- R2: The check bit at index 2^i gives even parity over every codeword index from 1 to 21 whose binary value has bit i set.
- R3: The encoded word and `enc_valid_o` appear exactly one clock after `enc_valid_i`. `enc_valid_o` is high in a cycle only when `enc_valid_i` was high in the cycle before.
- R4: A codeword without errors decodes to its data field, with `dec_fixed_o` = 0 and `dec_fatal_o` = 0.
- R5: A single flipped bit at any index from 1 to 21 is repaired. The original data appears with `dec_fixed_o` = 1 and `dec_fatal_o` = 0. A repair happens only when overall parity of the received word fails.
- R6: A flip of only the overall parity bit (index 0) leaves the data field untouched. The block then reports `dec_fixed_o` = 1 and `dec_fatal_o` = 0.
- R7: Any two flipped bits give `dec_fatal_o` = 1 and `dec_fixed_o` = 0, and the output data equals the received data field with no change. The two flags are never high together.
- R8: When overall parity fails and the syndrome names an index above 21, the block reports `dec_fatal_o` = 1 and passes the received data field through unchanged.
- R9: The decoder output appears exactly one clock after `dec_valid_i`. Both flags are 0 in any cycle where `dec_valid_o` is 0.
- R10: While `rst_n` is low, `enc_valid_o`, `dec_valid_o`, `dec_fixed_o` and `dec_fatal_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Data word to encode is present |
| enc_data_i | input | 16 | Data word to encode |
| enc_valid_o | output | 1 | Encoded word is present |
| enc_code_o | output | 22 | Encoded codeword |
| dec_valid_i | input | 1 | Codeword to decode is present |
| dec_code_i | input | 22 | Codeword to decode |
| dec_valid_o | output | 1 | Decoded result is present |
| dec_data_o | output | 16 | Decoded (repaired where possible) data |
| dec_fixed_o | output | 1 | A single-bit error was found and handled |
| dec_fatal_o | output | 1 | The error cannot be corrected |

## Verification
The assertions cover the properties that hold on every cycle:
- the valid signals follow their inputs with one cycle of delay;
- the flags are idle when no result is valid and are never both high;
- every encoded word has even overall parity;
- the all-zero codeword decodes clean;
- a repair is never reported for a received word whose overall parity holds.

Whether the right bit is flipped back, and whether the data passed through on a fatal error is the raw received field, can only be shown by the bench's scenarios. The bench encodes every possible data word and compares the result with a codeword it builds itself. It then applies every single flip and every pair of flips at all 22 indices to a spread of words, and adds flip patterns whose syndrome points past index 21.

// File: rtl/secded_codec.sv
module secded_codec #(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enc_valid_i,
  input  logic [DATA_W-1:0]   enc_data_i,
  output logic                enc_valid_o,
  output logic [21:0]         enc_code_o,
  input  logic                dec_valid_i,
  input  logic [21:0]         dec_code_i,
  output logic                dec_valid_o,
  output logic [DATA_W-1:0]   dec_data_o,
  output logic                dec_fixed_o,
  output logic                dec_fatal_o
);

  function automatic int chk_count(input int dw);
    int r;
    r = 0;
    for (int k = 1; k < 16; k++)
      if (r == 0 && (1 << k) >= dw + k + 1) r = k;
    return r;
  endfunction

  localparam int CHK_W = chk_count(DATA_W);
  localparam int N     = DATA_W + CHK_W;
  localparam int CW_W  = N + 1;
  localparam logic [CHK_W-1:0] TOP_POS = CHK_W'(N);

  function automatic int data_pos(input int j);
    int c, res;
    c = 0;
    res = 0;
    for (int p = 1; p <= N; p++)
      if ((p & (p - 1)) != 0) begin
        if (c == j) res = p;
        c++;
      end
    return res;
  endfunction

  logic [CW_W-1:0] enc_w;

  always_comb begin
    logic acc;
    enc_w = '0;
    for (int j = 0; j < DATA_W; j++) enc_w[data_pos(j)] = enc_data_i[j];
    for (int i = 0; i < CHK_W; i++) begin
      acc = 1'b0;
      for (int p = 1; p <= N; p++)
        if (p[i]) acc = acc ^ enc_w[p];
      enc_w[1 << i] = acc;
    end
    enc_w[0] = ^enc_w[N:1];
  end

  logic [CHK_W-1:0]  syn;
  logic              mpar_bad;
  logic [CW_W-1:0]   fixed_w;
  logic              single_ok;
  logic              fatal;
  logic [DATA_W-1:0] dec_d;

  always_comb begin
    for (int i = 0; i < CHK_W; i++) begin
      syn[i] = 1'b0;
      for (int p = 1; p <= N; p++)
        if (p[i]) syn[i] = syn[i] ^ dec_code_i[p];
    end
  end

  assign mpar_bad  = ^dec_code_i;
  assign single_ok = mpar_bad && (syn <= TOP_POS);
  assign fatal     = (!mpar_bad && syn != '0) || (mpar_bad && syn > TOP_POS);
  assign fixed_w   = single_ok ? (dec_code_i ^ (CW_W'(1) << syn)) : dec_code_i;

  always_comb begin
    for (int j = 0; j < DATA_W; j++) dec_d[j] = fixed_w[data_pos(j)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_valid_o <= 1'b0;
      enc_code_o  <= '0;
      dec_valid_o <= 1'b0;
      dec_data_o  <= '0;
      dec_fixed_o <= 1'b0;
      dec_fatal_o <= 1'b0;
    end else begin
      enc_valid_o <= enc_valid_i;
      if (enc_valid_i) enc_code_o <= enc_w;
      dec_valid_o <= dec_valid_i;
      dec_fixed_o <= dec_valid_i && single_ok;
      dec_fatal_o <= dec_valid_i && fatal;
      if (dec_valid_i) dec_data_o <= dec_d;
    end
  end

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enc_valid_i,
  input logic              enc_valid_o,
  input logic [21:0]       enc_code_o,
  input logic              dec_valid_i,
  input logic [21:0]       dec_code_i,
  input logic              dec_valid_o,
  input logic [DATA_W-1:0] dec_data_o,
  input logic              dec_fixed_o,
  input logic              dec_fatal_o
);

  assert_enc_valid_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid_i |=> enc_valid_o);
  assert_enc_valid_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_valid_i |=> !enc_valid_o);
  assert_enc_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid_o |-> (^enc_code_o) == 1'b0);
  assert_dec_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i |=> dec_valid_o);
  assert_dec_valid_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> !dec_valid_o);
  assert_flags_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_o |-> !dec_fixed_o && !dec_fatal_o);
  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_fixed_o && dec_fatal_o));
  assert_no_fix_good_par_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i && (^dec_code_i) == 1'b0 |=> !dec_fixed_o);
  assert_zero_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i && dec_code_i == '0 |=> !dec_fixed_o && !dec_fatal_o && dec_data_o == '0);

endmodule

bind secded_codec secded_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .enc_valid_i(enc_valid_i), .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
  .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i), .dec_valid_o(dec_valid_o),
  .dec_data_o(dec_data_o), .dec_fixed_o(dec_fixed_o), .dec_fatal_o(dec_fatal_o)
);

// File: tb/sim_secded_codec.sv
module sim_secded_codec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_valid_i = 1'b0;
  logic [15:0] enc_data_i = '0;
  logic enc_valid_o;
  logic [21:0] enc_code_o;
  logic dec_valid_i = 1'b0;
  logic [21:0] dec_code_i = '0;
  logic dec_valid_o;
  logic [15:0] dec_data_o;
  logic dec_fixed_o, dec_fatal_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  secded_codec u0 (.*);

  function automatic int bpos(input int j);
    case (j)
      0: return 3;   1: return 5;   2: return 6;   3: return 7;
      4: return 9;   5: return 10;  6: return 11;  7: return 12;
      8: return 13;  9: return 14;  10: return 15; 11: return 17;
      12: return 18; 13: return 19; 14: return 20; default: return 21;
    endcase
  endfunction

  function automatic logic [21:0] bench_enc(input logic [15:0] d);
    logic [21:0] cw;
    logic [4:0] s;
    cw = '0;
    s = '0;
    for (int j = 0; j < 16; j++)
      if (d[j]) begin
        cw[bpos(j)] = 1'b1;
        s = s ^ 5'(bpos(j));
      end
    cw[1] = s[0]; cw[2] = s[1]; cw[4] = s[2]; cw[8] = s[3]; cw[16] = s[4];
    cw[0] = ^cw[21:1];
    return cw;
  endfunction

  function automatic logic [15:0] bench_ext(input logic [21:0] cw);
    logic [15:0] d;
    for (int j = 0; j < 16; j++) d[j] = cw[bpos(j)];
    return d;
  endfunction

  task automatic enc_one(input logic [15:0] d);
    logic [21:0] exp;
    exp = bench_enc(d);
    enc_valid_i = 1'b1;
    enc_data_i = d;
    @(negedge clk);
    n_chk++;
    if (!enc_valid_o || enc_code_o !== exp) begin
      n_bad++;
      $display("FAIL R1/R2/R3 enc data=%h: got v=%b code=%h, expected v=1 code=%h",
               d, enc_valid_o, enc_code_o, exp);
    end
  endtask

  task automatic dec_one(input string req, input logic [21:0] cw,
                         input logic [15:0] ed, input logic ef, input logic ex);
    dec_valid_i = 1'b1;
    dec_code_i = cw;
    @(negedge clk);
    n_chk++;
    if (!dec_valid_o || dec_data_o !== ed || dec_fixed_o !== ef || dec_fatal_o !== ex) begin
      n_bad++;
      $display("FAIL %s code=%h: got v=%b d=%h fix=%b fat=%b, expected v=1 d=%h fix=%b fat=%b",
               req, cw, dec_valid_o, dec_data_o, dec_fixed_o, dec_fatal_o, ed, ef, ex);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [21:0] cw;
    logic [15:0] d;
    repeat (3) @(negedge clk);
    n_chk++;
    if (enc_valid_o || dec_valid_o || dec_fixed_o || dec_fatal_o) begin
      n_bad++;
      $display("FAIL R10 reset: got %b%b%b%b, expected 0000",
               enc_valid_o, dec_valid_o, dec_fixed_o, dec_fatal_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 65536; v++) enc_one(16'(v));
    enc_valid_i = 1'b0;
    @(negedge clk);
    n_chk++;
    if (enc_valid_o) begin
      n_bad++;
      $display("FAIL R3 enc idle: got v=1, expected v=0");
    end

    for (int w = 0; w < 128; w++) begin
      d = 16'(w * 521) ^ 16'(w << 9) ^ ((w == 1) ? 16'hffff : 16'h0);
      cw = bench_enc(d);
      dec_one("R4 clean", cw, d, 1'b0, 1'b0);
      dec_one("R6 master flip", cw ^ 22'd1, d, 1'b1, 1'b0);
      for (int a = 1; a < 22; a++)
        dec_one("R5 single flip", cw ^ (22'd1 << a), d, 1'b1, 1'b0);
      for (int a = 0; a < 22; a++)
        for (int b = a + 1; b < 22; b++)
          dec_one("R7 double flip", cw ^ (22'd1 << a) ^ (22'd1 << b),
                  bench_ext(cw ^ (22'd1 << a) ^ (22'd1 << b)), 1'b0, 1'b1);
      dec_one("R8 syndrome 22", cw ^ 22'h010014, d, 1'b0, 1'b1);
      dec_one("R8 syndrome 31", cw ^ 22'h010116, d, 1'b0, 1'b1);
    end

    dec_valid_i = 1'b0;
    @(negedge clk);
    n_chk++;
    if (dec_valid_o || dec_fixed_o || dec_fatal_o) begin
      n_bad++;
      $display("FAIL R9 dec idle: got v=%b fix=%b fat=%b, expected 000",
               dec_valid_o, dec_fixed_o, dec_fatal_o);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule